// File: doc/BRIEF.md
# Dual Performance Counter Unit

This block is the event-counting core of a processor performance monitor. It holds two 32-bit counters and one control word. Software reaches both through a single register port: one address holds the control word, and the other holds both counters packed as one 64-bit value. On every clock the block receives a vector of event pulses, indexed by event code, and the privilege level of the code now running. Each counter selects one event code. A counter advances by one when its selected pulse is high and the privilege level now in force is enabled.

The privilege enables are shared by both counters, so the pair always runs or stops together. To leave one counter effectively idle while the other works, software points it at an event that almost never fires. Either counter can wrap while software is not watching it, so each counter has its own sticky overflow flag. The interrupt request is the OR of the two flags, gated by an interrupt-enable bit.

Top module: `perf_counter_pair`

## Requirements
- R1: While `rst` is high, both counters, both event selects, the three privilege enables, the interrupt enable and both overflow flags go to zero, and `irq` is low.
- R2: Writing with `reg_sel`=1 loads both counters from `reg_wdata`: the upper counter from bits 63:32 and the lower counter from bits 31:0. Reading with `reg_sel`=1 returns them in the same layout.
- R3: The control word, read and written with `reg_sel`=0, has these fields: bit 0 enables user, bit 1 enables supervisor, bit 2 enables hypervisor, bit 3 enables the interrupt, bits 9:4 hold the lower counter's event select, bits 16:11 hold the upper counter's event select, bit 17 is the lower overflow flag and bit 18 is the upper overflow flag. All other bits read as zero. `reg_rdata` is registered: it shows the selected register as it stood at the clock edge after `reg_sel` was applied.
- R4: A counter adds exactly one on a cycle when `evt_vec[select]` is high and the current privilege level is enabled. Any code can be used on either counter. Code 0x00 is processor cycles and code 0x01 is retired instructions.
- R5: `priv_lvl` encodes 0 = user, 1 = supervisor, 2 = hypervisor and 3 = none. A counter counts only while the enable bit of the current level is set. Level 3 never counts. The same enables gate both counters.
- R6: When the upper select is 0x1C and the lower select is 0x14 (the rare-NOP codes), neither counter moves on any other event. Each counter advances only on its own parking event.
- R7: A counter that steps from 0xFFFFFFFF wraps to 0 and sets its own overflow flag. It does not set the other counter's flag.
- R8: Overflow flags are sticky. A control write with a 0 in a flag bit clears that flag, and a 1 leaves it unchanged. If a wrap happens in the same cycle as a clearing write, the flag ends up set.
- R9: `irq` is high exactly when the interrupt enable is set and at least one overflow flag is set. It changes on the same edge as the flags and the enable.
- R10: If a counter-register write and a counted event fall in the same cycle, the counter takes the written value and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = packed counters |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| evt_vec | input | 64 | Event pulses, bit n is event code n |
| priv_lvl | input | 2 | Current privilege level |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both deliberately. In the first, a counter-register write is driven on the same clock as a pulse on the selected event. The readback must equal the written value exactly, with no added one. In the second, a counter is parked at 0xFFFFFFFF and its event is pulsed while a control write puts 0 in that counter's overflow bit. The flag must still read set and `irq` must be high. Around these cases, the bench sweeps every privilege level against every enable combination, and every event code against the counter selects.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // privilege level seen on priv_lvl
  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_NONE = 2'd3
  } priv_e;

  // control word layout
  localparam int EN_POS     = 0;   // three privilege enables
  localparam int EN_W       = 3;
  localparam int IRQ_EN_POS = 3;
  localparam int LO_SEL_POS = 4;
  localparam int HI_SEL_POS = 11;
  localparam int OVF_POS    = 17;  // lower flag, upper flag at +1

  localparam int NUM_CTR = 2;      // index 0 = lower, 1 = upper

  function automatic int sel_pos(input int idx);
    return (idx == 0) ? LO_SEL_POS : HI_SEL_POS;
  endfunction
endpackage

// File: rtl/pcu_ctx_gate.sv
module pcu_ctx_gate
  import pcu_pkg::*;
(
  input  logic [EN_W-1:0] ctx_en,
  input  logic [1:0]      priv_lvl,
  output logic            live
);
  always_comb begin
    unique case (priv_e'(priv_lvl))
      PRIV_USER: live = ctx_en[0];
      PRIV_SUP:  live = ctx_en[1];
      PRIV_HYP:  live = ctx_en[2];
      default:   live = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // a load wins over a step in the same cycle
  assign wrap = inc & ~load & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/perf_counter_pair.sv
module perf_counter_pair
  import pcu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [2*CNT_W-1:0]   reg_wdata,
  output logic [2*CNT_W-1:0]   reg_rdata,
  input  logic [(1<<SEL_W)-1:0] evt_vec,
  input  logic [1:0]           priv_lvl,
  output logic                 irq
);
  localparam int REG_W = 2 * CNT_W;

  logic [EN_W-1:0]                 ctx_en_q;
  logic                            irq_en_q;
  logic [NUM_CTR-1:0][SEL_W-1:0]   sel_q;
  logic [NUM_CTR-1:0]              ovf_q;
  logic [NUM_CTR-1:0]              ovf_nxt;
  logic [NUM_CTR-1:0][CNT_W-1:0]   cnt_v;
  logic [NUM_CTR-1:0]              wrap_v;
  logic                            ctx_live;
  logic                            irq_en_nxt;
  logic                            ctrl_wr;
  logic                            cnt_wr;
  logic [REG_W-1:0]                ctrl_view;

  assign ctrl_wr = reg_wr & ~reg_sel;
  assign cnt_wr  = reg_wr &  reg_sel;

  pcu_ctx_gate u_gate (
    .ctx_en   (ctx_en_q),
    .priv_lvl (priv_lvl),
    .live     (ctx_live)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam int SP = sel_pos(i);

    pcu_counter #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_wr),
      .load_val (reg_wdata[i*CNT_W +: CNT_W]),
      .inc      (ctx_live & evt_vec[sel_q[i]]),
      .cnt      (cnt_v[i]),
      .wrap     (wrap_v[i])
    );

    always_ff @(posedge clk) begin
      if (rst)          sel_q[i] <= '0;
      else if (ctrl_wr) sel_q[i] <= reg_wdata[SP +: SEL_W];
    end

    // a set from a wrap beats a clearing write
    assign ovf_nxt[i] = wrap_v[i] |
                        (ovf_q[i] & (ctrl_wr ? reg_wdata[OVF_POS+i] : 1'b1));
  end

  assign irq_en_nxt = ctrl_wr ? reg_wdata[IRQ_EN_POS] : irq_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_en_q <= '0;
      irq_en_q <= 1'b0;
      ovf_q    <= '0;
      irq      <= 1'b0;
    end else begin
      if (ctrl_wr) ctx_en_q <= reg_wdata[EN_POS +: EN_W];
      irq_en_q <= irq_en_nxt;
      ovf_q    <= ovf_nxt;
      irq      <= irq_en_nxt & (|ovf_nxt);
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[EN_POS +: EN_W]        = ctx_en_q;
    ctrl_view[IRQ_EN_POS]            = irq_en_q;
    ctrl_view[LO_SEL_POS +: SEL_W]   = sel_q[0];
    ctrl_view[HI_SEL_POS +: SEL_W]   = sel_q[1];
    ctrl_view[OVF_POS +: NUM_CTR]    = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_sel ? cnt_v : ctrl_view;
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_wr,
  input logic                       reg_sel,
  input logic [2*CNT_W-1:0]         reg_wdata,
  input logic [(1<<SEL_W)-1:0]      evt_vec,
  input logic [1:0]                 priv_lvl,
  input logic                       irq,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CTR-1:0][SEL_W-1:0] sel_q,
  input logic [EN_W-1:0]            ctx_en_q,
  input logic                       irq_en_q,
  input logic [NUM_CTR-1:0]         ovf_q
);
  logic lvl_on;
  assign lvl_on = (priv_lvl != 2'd3) && ctx_en_q[priv_lvl];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt_v == '0) && (ovf_q == '0) && (ctx_en_q == '0) && !irq); // R1

  AST_COUNTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |=> (cnt_v == $past(reg_wdata))); // R10

  AST_CTX_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !lvl_on) |=> $stable(cnt_v)); // R5

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_en_q && (|ovf_q))); // R9

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      !reg_wr |=> (cnt_v[i] == $past(cnt_v[i])) ||
                  (cnt_v[i] == $past(cnt_v[i]) + 1'b1)); // R4

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
      (!reg_wr && lvl_on && evt_vec[sel_q[i]] && (&cnt_v[i])) |=> ovf_q[i]); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovf_q[i] && !(reg_wr && !reg_sel)) |=> ovf_q[i]); // R8
  end
endmodule

bind perf_counter_pair pcu_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .evt_vec   (evt_vec),
  .priv_lvl  (priv_lvl),
  .irq       (irq),
  .cnt_v     (cnt_v),
  .sel_q     (sel_q),
  .ctx_en_q  (ctx_en_q),
  .irq_en_q  (irq_en_q),
  .ovf_q     (ovf_q)
);

// File: tb/sim_perf_counter_pair.sv
module sim_perf_counter_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [63:0] evt_vec = '0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_pair u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_vec(evt_vec),
    .priv_lvl(priv_lvl), .irq(irq)
  );

  function automatic logic [63:0] mk_ctrl(input logic [2:0] en, input logic ie,
                                          input logic [5:0] lo, input logic [5:0] hi,
                                          input logic [1:0] ovf);
    logic [63:0] v;
    v = '0;
    v[2:0]   = en;
    v[3]     = ie;
    v[9:4]   = lo;
    v[16:11] = hi;
    v[18:17] = ovf;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic wr(input logic sel, input logic [63:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] d);
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [63:0] m, input int n);
    evt_vec = m;
    repeat (n) @(negedge clk);
    evt_vec = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [31:0] elo, ehi;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(1'b1, d); check("R1 counters", d, 64'h0);
    rd(1'b0, d); check("R1 control", d, 64'h0);
    check("R1 irq", {63'h0, irq}, 64'h0);

    // R3 layout, spare bits zero, writing 1 to flags sets nothing
    wr(1'b0, '1);
    rd(1'b0, d); check("R3 all-ones write", d, 64'h1FBFF);
    wr(1'b0, 64'h0);

    // R2 packed counter layout
    wr(1'b1, 64'hA5A5_0001_5A5A_0002);
    rd(1'b1, d); check("R2 readback", d, 64'hA5A5_0001_5A5A_0002);

    // R5 / R4 privilege x enable sweep; lower on code 0, upper on code 1
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 8; e++) begin
        wr(1'b0, mk_ctrl(3'(e), 1'b0, 6'h00, 6'h01, 2'b00));
        wr(1'b1, 64'h0);
        priv_lvl = 2'(p);
        pulse(64'h3, 2);
        pulse(64'h1, 1);
        elo = (p < 3 && e[p]) ? 32'd3 : 32'd0;
        ehi = (p < 3 && e[p]) ? 32'd2 : 32'd0;
        rd(1'b1, d); check("R5 context gating", d, {ehi, elo});
      end
    end
    priv_lvl = 2'd0;

    // R4 code sweep: lower on c, upper on 63-c, only bit c pulses
    for (int c = 0; c < 64; c++) begin
      wr(1'b0, mk_ctrl(3'b001, 1'b0, 6'(c), 6'(63 - c), 2'b00));
      wr(1'b1, 64'h0);
      pulse(64'h1 << c, 2);
      rd(1'b1, d); check("R4 event select", d, {32'd0, 32'd2});
    end

    // R6 parked codes
    wr(1'b0, mk_ctrl(3'b111, 1'b0, 6'h14, 6'h1C, 2'b00));
    wr(1'b1, 64'h0);
    pulse(~((64'h1 << 6'h14) | (64'h1 << 6'h1C)), 4);
    rd(1'b1, d); check("R6 parked ignores others", d, 64'h0);
    pulse(64'h1 << 6'h1C, 1);
    pulse(64'h1 << 6'h14, 2);
    rd(1'b1, d); check("R6 parked own events", d, {32'd1, 32'd2});

    // R7 wrap, per-counter flags; R9 irq
    wr(1'b0, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b00));
    wr(1'b1, {32'hFFFF_FFFE, 32'hFFFF_FFFF});
    pulse(64'h1, 1);
    check("R9 irq after lower wrap", {63'h0, irq}, 64'h1);
    rd(1'b1, d); check("R7 lower wraps", d, {32'hFFFF_FFFF, 32'h0});
    rd(1'b0, d); check("R7 only lower flag", d, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b01));
    pulse(64'h1, 1);
    rd(1'b1, d); check("R7 upper wraps", d, {32'h0, 32'h1});
    rd(1'b0, d); check("R7 both flags", d, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b11));

    // R8 clear by 0, keep by 1
    wr(1'b0, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b10));
    rd(1'b0, d); check("R8 selective clear", d, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b10));
    check("R9 irq with upper flag", {63'h0, irq}, 64'h1);
    wr(1'b0, mk_ctrl(3'b001, 1'b0, 6'h00, 6'h00, 2'b10));
    check("R9 irq masked", {63'h0, irq}, 64'h0);
    wr(1'b0, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b00));
    check("R9 irq after clear", {63'h0, irq}, 64'h0);

    // R8 wrap in the same cycle as a clearing write
    wr(1'b1, {32'h0, 32'hFFFF_FFFF});
    evt_vec = 64'h1;
    reg_wr = 1'b1; reg_sel = 1'b0;
    reg_wdata = mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b00);
    @(negedge clk);
    reg_wr = 1'b0; evt_vec = '0;
    check("R9 irq on overlap", {63'h0, irq}, 64'h1);
    rd(1'b0, d); check("R8 set beats clear", d, mk_ctrl(3'b001, 1'b1, 6'h00, 6'h00, 2'b01));

    // R10 counter write beats increment
    wr(1'b0, mk_ctrl(3'b001, 1'b0, 6'h00, 6'h00, 2'b00));
    evt_vec = 64'h1;
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    reg_wr = 1'b0; evt_vec = '0;
    rd(1'b1, d); check("R10 write wins", d, 64'h1234_5678_9ABC_DEF0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule